// File: doc/BRIEF.md
# Sleep-State Power Rail Sequencer

This controller turns two sleep request lines into one of three power states: running, suspend-to-RAM, or soft-off. From that state it drives digital enables for the switchable supply rails and a source select for the always-on 3.3 V rail. A downstream regulator block acts on these enables. Each request line passes a short stability filter, so noise on long board traces cannot trip a sleep transition. A low on the S3 line while running starts an entry delay. When the delay ends, the S5 line picks the sleep depth.

Internally the state machine has four states. `SQ_RUN` is running. `SQ_ARM` is running with the entry delay counting. `SQ_RAM` is suspend-to-RAM and `SQ_OFF` is soft-off. The named transitions are: arm (RUN→ARM when filtered S3 falls), cancel (ARM→RUN when filtered S3 returns high), expire-to-RAM (ARM→RAM, delay over, S5 high), expire-to-off (ARM→OFF, delay over, S5 low), deepen (RAM→OFF, both lines low), wake (RAM or OFF→RUN, both lines high) and hold (every other case). Two strap inputs choose which rails stay powered in sleep. One keeps the 5 V dual rail on in soft-off. The other keeps the auxiliary VOUT1 rail on in both sleep states.

Top module: `sleep_power_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, the block is in soft-off: `state_o` is 10, `en_1v2_o` and `sel_3v3_main_o` are 0, and the strap-dependent enables follow R8 and R10.
- R2: A change on `req_s3_i` or `req_s5_i` takes effect only after the new level has been sampled on FILT_US×CLK_HZ/1e6 consecutive clock edges (2 by default). A shorter pulse has no effect.
- R3: `state_o` reports 00 for running (including while the entry delay counts), 01 for suspend-to-RAM and 10 for soft-off. It never shows 11.
- R4: When filtered S3 falls while running, the block keeps running for DELAY_US×CLK_HZ/1e6 clocks (200 by default). It then enters soft-off if filtered S5 is low and suspend-to-RAM if it is high.
- R5: If filtered S3 returns high before the entry delay ends, the block stays running. A later fall restarts the full delay.
- R6: While the filtered inputs are S5 low and S3 high, the state and every output hold their previous values.
- R7: Soft-off never moves to suspend-to-RAM: S3 low with S5 high in soft-off has no effect. Suspend-to-RAM moves to soft-off with no delay when both inputs are low. Either sleep state wakes with no delay when both inputs are high.
- R8: `en_5vdual_o` is 1 when running and in suspend-to-RAM. In soft-off it equals `strap_en5_i`.
- R9: `sel_3v3_main_o` is 1 only when running and `main_good_i` is 1. Otherwise the 3.3 V rail is fed from standby.
- R10: `en_vout1_o` is 1 when running. In either sleep state it equals `strap_lan_i`.
- R11: `en_1v2_o` is 1 only when running and 0 in both sleep states, whatever the straps are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_s3_i | input | 1 | S3 sleep request, low requests sleep |
| req_s5_i | input | 1 | S5 sleep depth, low selects soft-off |
| strap_en5_i | input | 1 | High keeps the 5 V dual rail on in soft-off |
| strap_lan_i | input | 1 | High keeps VOUT1 on in both sleep states |
| main_good_i | input | 1 | Main supply is good |
| state_o | output | 2 | Power state code (see R3) |
| en_5vdual_o | output | 1 | 5 V dual rail enable |
| sel_3v3_main_o | output | 1 | 3.3 V rail source: 1 main, 0 standby |
| en_vout1_o | output | 1 | VOUT1 rail enable |
| en_1v2_o | output | 1 | 1.2 V rail enable |

## Verification
A wrong state shows at the ports on the same clock edge, because every output is decoded from the state register with no extra register. A soft-off taken as suspend-to-RAM shows up at once on `state_o` and, with the EN5 strap low, on `en_5vdual_o`. A wrong entry-delay count is harder to see: it appears only when the delay ends, as a state change one or more cycles away from the expected edge. The reference model therefore compares every output on every clock, so an off-by-one in the filter or the timer is caught at the exact cycle.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

    typedef enum logic [1:0] {
        SQ_RUN = 2'd0,
        SQ_ARM = 2'd1,
        SQ_RAM = 2'd2,
        SQ_OFF = 2'd3
    } seq_state_t;

    localparam logic [1:0] RPT_ACTIVE  = 2'b00;
    localparam logic [1:0] RPT_SUSPEND = 2'b01;
    localparam logic [1:0] RPT_SOFTOFF = 2'b10;

endpackage

// File: rtl/sleep_req_filter.sv
module sleep_req_filter #(
    parameter int STABLE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

    logic [CW-1:0] run_q;

    // Output flips only once the new level has been seen on STABLE_CYC edges in a row.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clean_o <= 1'b0;
            run_q   <= '0;
        end else if (raw_i != clean_o) begin
            if (run_q == LAST) begin
                clean_o <= raw_i;
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end
endmodule

// File: rtl/sleep_entry_timer.sv
module sleep_entry_timer #(
    parameter int DELAY_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);
    localparam int CW = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/sleep_state_fsm.sv
module sleep_state_fsm
    import sleep_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       s3_f_i,
    input  logic       s5_f_i,
    input  logic       expire_i,
    output seq_state_t st_o,
    output logic       arm_o
);
    seq_state_t st_q, st_d;
    logic both_hi, both_lo;

    assign both_hi = s3_f_i && s5_f_i;
    assign both_lo = !s3_f_i && !s5_f_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SQ_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_RUN: begin
                if (!s3_f_i) st_d = SQ_ARM;          // arm
            end
            SQ_ARM: begin
                if (s3_f_i)        st_d = SQ_RUN;    // cancel
                else if (expire_i) st_d = s5_f_i ? SQ_RAM : SQ_OFF;
            end
            SQ_RAM: begin
                if (both_hi)      st_d = SQ_RUN;     // wake
                else if (both_lo) st_d = SQ_OFF;     // deepen
            end
            SQ_OFF: begin
                if (both_hi) st_d = SQ_RUN;          // wake; S3 request ignored
            end
            default: st_d = SQ_OFF;
        endcase
    end

    assign st_o  = st_q;
    assign arm_o = (st_q == SQ_ARM);
endmodule

// File: rtl/rail_enable_decode.sv
module rail_enable_decode
    import sleep_seq_pkg::*;
(
    input  seq_state_t st_i,
    input  logic       strap_en5_i,
    input  logic       strap_lan_i,
    input  logic       main_good_i,
    output logic [1:0] state_o,
    output logic       en_5vdual_o,
    output logic       sel_3v3_main_o,
    output logic       en_vout1_o,
    output logic       en_1v2_o
);
    always_comb begin
        unique case (st_i)
            SQ_RUN, SQ_ARM: begin
                state_o        = RPT_ACTIVE;
                en_5vdual_o    = 1'b1;
                sel_3v3_main_o = main_good_i;
                en_vout1_o     = 1'b1;
                en_1v2_o       = 1'b1;
            end
            SQ_RAM: begin
                state_o        = RPT_SUSPEND;
                en_5vdual_o    = 1'b1;
                sel_3v3_main_o = 1'b0;
                en_vout1_o     = strap_lan_i;
                en_1v2_o       = 1'b0;
            end
            default: begin
                state_o        = RPT_SOFTOFF;
                en_5vdual_o    = strap_en5_i;
                sel_3v3_main_o = 1'b0;
                en_vout1_o     = strap_lan_i;
                en_1v2_o       = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sleep_power_sequencer.sv
module sleep_power_sequencer
    import sleep_seq_pkg::*;
#(
    parameter int CLK_HZ   = 1_000_000,
    parameter int FILT_US  = 2,
    parameter int DELAY_US = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_s3_i,
    input  logic       req_s5_i,
    input  logic       strap_en5_i,
    input  logic       strap_lan_i,
    input  logic       main_good_i,
    output logic [1:0] state_o,
    output logic       en_5vdual_o,
    output logic       sel_3v3_main_o,
    output logic       en_vout1_o,
    output logic       en_1v2_o
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int FILT_RAW   = CYC_PER_US * FILT_US;
    localparam int DELAY_RAW  = CYC_PER_US * DELAY_US;
    localparam int FILT_CYC   = (FILT_RAW  < 1) ? 1 : FILT_RAW;
    localparam int DELAY_CYC  = (DELAY_RAW < 1) ? 1 : DELAY_RAW;
    localparam int NREQ       = 2;

    logic [NREQ-1:0] req_raw, req_f;
    logic s3_f, s5_f;
    logic arm, expire;
    seq_state_t st;

    assign req_raw = {req_s5_i, req_s3_i};

    for (genvar gi = 0; gi < NREQ; gi++) begin : g_filt
        sleep_req_filter #(.STABLE_CYC(FILT_CYC)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (req_raw[gi]),
            .clean_o (req_f[gi])
        );
    end

    assign s3_f = req_f[0];
    assign s5_f = req_f[1];

    sleep_entry_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (arm),
        .expire_o (expire)
    );

    sleep_state_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .s3_f_i   (s3_f),
        .s5_f_i   (s5_f),
        .expire_i (expire),
        .st_o     (st),
        .arm_o    (arm)
    );

    rail_enable_decode u_dec (
        .st_i           (st),
        .strap_en5_i    (strap_en5_i),
        .strap_lan_i    (strap_lan_i),
        .main_good_i    (main_good_i),
        .state_o        (state_o),
        .en_5vdual_o    (en_5vdual_o),
        .sel_3v3_main_o (sel_3v3_main_o),
        .en_vout1_o     (en_vout1_o),
        .en_1v2_o       (en_1v2_o)
    );
endmodule

// File: rtl/sleep_power_sequencer_chk.sv
module sleep_power_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_s3_i,
    input logic       req_s5_i,
    input logic       s3_f,
    input logic       s5_f,
    input logic       strap_en5_i,
    input logic       strap_lan_i,
    input logic       main_good_i,
    input logic [1:0] state_o,
    input logic       en_5vdual_o,
    input logic       sel_3v3_main_o,
    input logic       en_vout1_o,
    input logic       en_1v2_o
);
    a_r2_s3_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s3_f) |-> (s3_f == $past(req_s3_i)));

    a_r2_s5_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s5_f) |-> (s5_f == $past(req_s5_i)));

    a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != 2'b11);

    a_r6_illegal_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (s3_f && !s5_f) |=> $stable(state_o));

    a_r7_no_off_to_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b10) |=> (state_o != 2'b01));

    a_r8_5v_on_unless_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'b10) |-> en_5vdual_o);

    a_r8_5v_off_strap: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b10) |-> (en_5vdual_o == strap_en5_i));

    a_r9_main_select: assert property (@(posedge clk) disable iff (!rst_n)
        sel_3v3_main_o |-> ((state_o == 2'b00) && main_good_i));

    a_r10_vout1_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'b00) |-> (en_vout1_o == strap_lan_i));

    a_r11_1v2_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'b00) |-> !en_1v2_o);
endmodule

bind sleep_power_sequencer sleep_power_sequencer_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_s3_i       (req_s3_i),
    .req_s5_i       (req_s5_i),
    .s3_f           (s3_f),
    .s5_f           (s5_f),
    .strap_en5_i    (strap_en5_i),
    .strap_lan_i    (strap_lan_i),
    .main_good_i    (main_good_i),
    .state_o        (state_o),
    .en_5vdual_o    (en_5vdual_o),
    .sel_3v3_main_o (sel_3v3_main_o),
    .en_vout1_o     (en_vout1_o),
    .en_1v2_o       (en_1v2_o)
);

// File: tb/test_sleep_power_sequencer.sv
`timescale 1ns/1ps
module test_sleep_power_sequencer;
    localparam int FILT  = 2;
    localparam int DELAY = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s3 = 1'b0, s5 = 1'b0, en5 = 1'b1, lan = 1'b1, good = 1'b1;
    logic [1:0] state_o;
    logic en_5v, sel_main, en_v1, en_12;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sleep_power_sequencer i_sleep_power_sequencer (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_s3_i       (s3),
        .req_s5_i       (s5),
        .strap_en5_i    (en5),
        .strap_lan_i    (lan),
        .main_good_i    (good),
        .state_o        (state_o),
        .en_5vdual_o    (en_5v),
        .sel_3v3_main_o (sel_main),
        .en_vout1_o     (en_v1),
        .en_1v2_o       (en_12)
    );

    // Reference model: 0 running, 1 running with delay pending, 2 suspend, 3 soft-off
    int m_st = 3;
    int m_tmr = 0;
    int m_f3 = 0, m_f5 = 0, m_c3 = 0, m_c5 = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 3; m_tmr = 0; m_f3 = 0; m_f5 = 0; m_c3 = 0; m_c5 = 0;
        end else begin
            case (m_st)
                0: if (m_f3 == 0) begin m_st = 1; m_tmr = 0; end
                1: begin
                    if (m_f3 == 1) m_st = 0;
                    else if (m_tmr == DELAY - 1) m_st = (m_f5 == 1) ? 2 : 3;
                    else m_tmr = m_tmr + 1;
                end
                2: begin
                    if (m_f3 == 1 && m_f5 == 1) m_st = 0;
                    else if (m_f3 == 0 && m_f5 == 0) m_st = 3;
                end
                default: if (m_f3 == 1 && m_f5 == 1) m_st = 0;
            endcase
            if (int'(s3) != m_f3) begin
                if (m_c3 == FILT - 1) begin m_f3 = int'(s3); m_c3 = 0; end
                else m_c3 = m_c3 + 1;
            end else m_c3 = 0;
            if (int'(s5) != m_f5) begin
                if (m_c5 == FILT - 1) begin m_f5 = int'(s5); m_c5 = 0; end
                else m_c5 = m_c5 + 1;
            end else m_c5 = 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Compare every output against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            automatic int run = (m_st <= 1) ? 1 : 0;
            chk("R3/R4 state", int'(state_o), run ? 0 : (m_st == 2 ? 1 : 2));
            chk("R8 en_5vdual", int'(en_5v), (m_st == 3) ? int'(en5) : 1);
            chk("R9 sel_main", int'(sel_main), run ? int'(good) : 0);
            chk("R10 en_vout1", int'(en_v1), run ? 1 : int'(lan));
            chk("R11 en_1v2", int'(en_12), run);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic finish_run;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        wait_cyc(3);
        chk("R1 reset state", int'(state_o), 2);
        chk("R1 reset 1v2", int'(en_12), 0);
        rst_n = 1'b1;
        wait_cyc(2);
        chk("R1 post-reset state", int'(state_o), 2);
        chk("R1 post-reset sel_main", int'(sel_main), 0);

        // R2: one-cycle wake pulse ignored
        s3 = 1; s5 = 1;
        wait_cyc(1);
        s3 = 0; s5 = 0;
        wait_cyc(8);
        chk("R2 glitch ignored", int'(state_o), 2);

        // wake from soft-off
        s3 = 1; s5 = 1;
        wait_cyc(5);
        chk("R7 wake from off", int'(state_o), 0);
        chk("R9 main selected", int'(sel_main), 1);
        good = 0;
        wait_cyc(1);
        chk("R9 standby when main bad", int'(sel_main), 0);
        good = 1;

        // R5: cancel before expiry
        s3 = 0;
        wait_cyc(100);
        chk("R4 still running during delay", int'(state_o), 0);
        s3 = 1;
        wait_cyc(DELAY + 20);
        chk("R5 cancelled stays running", int'(state_o), 0);

        // R4: full delay to suspend
        s3 = 0;
        wait_cyc(DELAY + 5);
        chk("R4 suspend after delay", int'(state_o), 1);
        chk("R11 1v2 off in suspend", int'(en_12), 0);
        chk("R10 vout1 lan high", int'(en_v1), 1);

        // R6: disallowed combination holds
        s3 = 1; s5 = 0;
        wait_cyc(10);
        chk("R6 hold in suspend", int'(state_o), 1);

        // R7: deepen to soft-off
        s3 = 0; s5 = 0;
        wait_cyc(5);
        chk("R7 suspend to off", int'(state_o), 2);
        en5 = 0; lan = 0;
        wait_cyc(1);
        chk("R8 5v off with strap low", int'(en_5v), 0);
        chk("R10 vout1 off with lan low", int'(en_v1), 0);

        // R7: S3 request from soft-off ignored
        s5 = 1;
        wait_cyc(DELAY + 10);
        chk("R7 no off to suspend", int'(state_o), 2);
        chk("R8 5v still off", int'(en_5v), 0);

        // wake, then illegal combo while running, then sleep with S5 low
        s3 = 1;
        wait_cyc(5);
        chk("R7 wake", int'(state_o), 0);
        s5 = 0;
        wait_cyc(20);
        chk("R6 hold while running", int'(state_o), 0);
        s3 = 0;
        wait_cyc(DELAY + 5);
        chk("R4 soft-off after delay", int'(state_o), 2);
        en5 = 1;
        wait_cyc(1);
        chk("R8 5v on with strap high", int'(en_5v), 1);

        // reset mid-run
        rst_n = 0;
        wait_cyc(2);
        chk("R1 reset again", int'(state_o), 2);
        rst_n = 1;
        wait_cyc(5);
        finish_run();
    end
endmodule